// File: doc/BRIEF.md
# Register File with Input Bypass

This block is a small register file for an accumulator datapath. It holds four registers. A 2-bit index selects one of them. Writes happen only on the rising clock edge, through a single write port. The single read port is combinational.

The read port has two sources. When read enable is high, the output shows the selected register. When read enable is low, the output carries the write-data input straight through. This path lets an immediate operand reach the accumulator without being stored first.

A read of a register during the cycle it is written still shows the old contents. The new value appears one cycle later. There is no forwarding from the write port to the read port.

Top module: `regfile_bypass`

## Requirements
- R1: An active-high synchronous reset clears all four registers to zero at the rising clock edge where `rst` is sampled high.
- R2: When `wrEn` is high at a rising clock edge, the register addressed by `regIdx` takes the value of `wrData`.
- R3: When `rdEn` is high, `rdData` equals the contents of the register addressed by `regIdx`. The port is combinational, so a change of `regIdx` shows in the same cycle.
- R4: When `rdEn` is low, `rdData` equals `wrData` combinationally. This holds for any `regIdx` and any `wrEn`.
- R5: A read of a register in the cycle it is being written returns the old value. The written value is visible from the next cycle on.
- R6: When `rdEn` and `wrEn` are both high, `rdData` shows the stored register value and not `wrData`.
- R7: When `wrEn` is low at a clock edge, no register changes, whatever `regIdx` and `wrData` are.
- R8: A write to one index leaves the other three registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; storage updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| regIdx | input | 2 | Register index for both reading and writing |
| wrEn | input | 1 | Write enable |
| rdEn | input | 1 | Read enable; when low, the output bypasses `wrData` |
| wrData | input | 8 | Write data, which is also the bypass source |
| rdData | output | 8 | Read data |

## Verification
The block has no state output of its own. A wrong register value is seen only when that index is read with `rdEn` high. It shows in the same cycle as the read, and it can stay hidden until then. The bench therefore reads back all four registers after every write, every idle stretch and every reset. This catches stray writes to a neighbour index, and writes that happen while `wrEn` is low. Errors in the bypass path and in the same-cycle read show at once on `rdData`. The bench checks them in the cycle before the clock edge that commits the write.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 2;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic writeStrobe;   // commit wrData at the next rising edge
    logic clearAll;      // synchronous clear of all storage
    logic showStored;    // drive the addressed register onto the read port
  } rfStrobes_t;
endpackage

// File: rtl/regfile_ctrl.sv
module regfile_ctrl
  import regfile_pkg::*;
(
  input  logic       rst,
  input  logic       wrEn,
  input  logic       rdEn,
  output rfStrobes_t strobes
);
  always_comb begin
    strobes             = '0;
    strobes.clearAll    = rst;
    // Reset takes priority over a write in the same cycle
    strobes.writeStrobe = wrEn && !rst;
    // A stored value wins over the bypass when read is enabled (R6)
    strobes.showStored  = rdEn;
  end
endmodule

// File: rtl/regfile_datapath.sv
module regfile_datapath
  import regfile_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst,
  input  rfStrobes_t    strobes,
  input  logic [IW-1:0] regIdx,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData
);
  localparam int DEPTH = 1 << IW;

  logic [DW-1:0] regs [DEPTH];
  logic [DEPTH-1:0] rowSel;

  always_comb begin
    rowSel = '0;
    rowSel[regIdx] = 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gRow
    always_ff @(posedge clk) begin
      if (strobes.clearAll)
        regs[g] <= '0;
      else if (strobes.writeStrobe && rowSel[g])
        regs[g] <= wrData;
    end

    // R1: every row is zero after a reset edge
    assert_reset_clear_R1: assert property (@(posedge clk)
      $past(rst) |-> regs[g] == '0);

    // R7 / R8: a row not addressed by a write holds its value
    assert_row_hold_R7: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && !($past(strobes.writeStrobe) && $past(regIdx) == IW'(g)))
        |-> regs[g] == $past(regs[g]));
  end

  always_comb begin
    if (strobes.showStored)
      rdData = regs[regIdx];
    else
      rdData = wrData;
  end

  // R2: the addressed row holds the written data after the edge
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    strobes.writeStrobe |=> regs[$past(regIdx)] == $past(wrData));

  // R4: bypass path follows the input when read is disabled
  assert_bypass_R4: assert property (@(posedge clk) disable iff (rst)
    !strobes.showStored |-> rdData == wrData);

  // R5: a read after a write to the same index returns the written data
  assert_read_after_write_R5: assert property (@(posedge clk) disable iff (rst)
    (strobes.writeStrobe && strobes.showStored) ##1
      (strobes.showStored && regIdx == $past(regIdx))
      |-> rdData == $past(wrData));
endmodule

// File: rtl/regfile_bypass.sv
module regfile_bypass
  import regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  rfStrobes_t strobes;

  regfile_ctrl u_ctrl (
    .rst     (rst),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .strobes (strobes)
  );

  regfile_datapath #(.DW(DATA_W), .IW(IDX_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .regIdx  (regIdx),
    .wrData  (wrData),
    .rdData  (rdData)
  );
endmodule

// File: tb/regfile_bypass_bench.sv
module regfile_bypass_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] regIdx = '0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  logic [7:0] model [4];

  always #10 clk = ~clk;   // 50 MHz

  regfile_bypass u_regfile_bypass (
    .clk(clk), .rst(rst), .regIdx(regIdx), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .rdData(rdData)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [1:0] idx, input logic [7:0] d);
    @(negedge clk);
    regIdx = idx; wrData = d; wrEn = 1'b1; rdEn = 1'b0;
    @(negedge clk);
    wrEn = 1'b0;
    model[idx] = d;
  endtask

  task automatic readAll(input string req);
    for (int i = 0; i < 4; i++) begin
      regIdx = 2'(i); rdEn = 1'b1; wrData = 8'h5A;
      #2;
      check(req, rdData, model[i]);
    end
    rdEn = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 4; i++) model[i] = '0;
    readAll("R1 reset clear");
  endtask

  task automatic testWrites();
    doWrite(2'd0, 8'h11);
    doWrite(2'd1, 8'hA2);
    doWrite(2'd2, 8'h3C);
    doWrite(2'd3, 8'hFF);
    readAll("R2/R8 write and isolation");
    doWrite(2'd1, 8'h00);
    readAll("R8 neighbours unchanged");
  endtask

  task automatic testReadMux();
    @(negedge clk);
    rdEn = 1'b1;
    regIdx = 2'd3; #2; check("R3 read idx3", rdData, model[3]);
    regIdx = 2'd0; #2; check("R3 read idx0 same cycle", rdData, model[0]);
    rdEn = 1'b0;
  endtask

  task automatic testBypass();
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0;
    regIdx = 2'd2; wrData = 8'h77; #2; check("R4 bypass", rdData, 8'h77);
    wrData = 8'h08; #2; check("R4 bypass follows input", rdData, 8'h08);
    wrEn = 1'b1; regIdx = 2'd1; wrData = 8'hC3; #2;
    check("R4 bypass while writing", rdData, 8'hC3);
    @(negedge clk); wrEn = 1'b0;
    model[1] = 8'hC3;
  endtask

  task automatic testSameCycle();
    @(negedge clk);
    regIdx = 2'd2; wrData = 8'h9E; wrEn = 1'b1; rdEn = 1'b1;
    #2;
    check("R5 old value in write cycle", rdData, model[2]);
    check("R6 stored not input", rdData, 8'h3C);
    @(negedge clk);
    wrEn = 1'b0; model[2] = 8'h9E;
    #2;
    check("R5 new value next cycle", rdData, 8'h9E);
    rdEn = 1'b0;
  endtask

  task automatic testIdle();
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    for (int i = 0; i < 4; i++) begin
      regIdx = 2'(i); wrData = 8'hE0 + 8'(i);
      @(negedge clk);
    end
    readAll("R7 no write when disabled");
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    testReset();
    testWrites();
    testReadMux();
    testBypass();
    readAll("R4 bypass write landed");
    testSameCycle();
    testIdle();
    testReset();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule